// File: doc/BRIEF.md
# Secure Boot Reset Sequencer

This block runs the power-on chain of integrity steps that decides which processing stages of a chip are allowed to leave reset. When the supply is reported good it latches the requested security mode, clears a bank of management registers and proves the clear by reading every entry back. It optionally runs a built-in self test, and it asks an external hash engine to digest the second stage's immutable ROM. The returned digest is compared with a stored golden digest one 32-bit word per cycle. The second stage leaves reset only when every word matches. The same hash-and-compare step then covers the third stage's ROM. A failure there is recorded but does not stop boot by default.

After the third stage reports that its boot image is loaded, the sequencer asks for the crypto-engine storage to be wiped. Once that request is acknowledged, it releases exactly one final target, either the application processor or the real-time processor. Each failed step sets its own bit in an error status word. Three fuse inputs control the rest: one hides that word from the debug port, one enables the self test, and one turns any boot error into a terminal lockdown that holds every downstream reset. The hash engine, the self-test logic, the register bank and the wipe logic sit outside the block behind simple request/done handshakes. Every handshake is guarded by a timeout.

Top module: `sboot_seq`

## Requirements
- R1: While `por_n` is low, every downstream reset output is low (asserted), `lockdown_o` is 0, the error word is 0, and every request output (`bank_clr_o`, `bist_start_o`, `hash_start_o`, `czero_req_o`) is 0.
- R2: After `power_ok` is seen, `bank_clr_o` pulses once and then the addresses 0 to NREGS-1 are read in turn. Any nonzero readback, including at the last address, sets error bit 0, and boot continues.
- R3: The self test starts (`bist_start_o`) only when `fuse_bist_en` is 1. A done with `bist_pass_i`=0 or a timeout sets error bit 1, and boot continues.
- R4: The first digest check uses `hash_rom_sel_o`=0 and compares DIG_W/WORD_W words (12 by default) at `dig_idx_o` 0 upward. A mismatch in any word, including the last, sets error bit 2, and `rst_s2_n_o` then stays low until power-on reset.
- R5: After `rst_s2_n_o` is released, a second digest check runs with `hash_rom_sel_o`=1. A mismatch sets error bit 3, yet `rst_s3_n_o` is still released.
- R6: `err_status_o` always shows the error word. `dbg_err_o` equals it when `fuse_err_hide` is 0 and reads all zeros when `fuse_err_hide` is 1.
- R7: With `fuse_lock_on_err` set, any error bit drives `lockdown_o` to 1 and all four downstream resets low, including ones already released, until power-on reset.
- R8: `secure_mode_o` takes the value of `mode_secure_i` when `power_ok` is first seen. Later changes of `mode_secure_i` have no effect until power-on reset.
- R9: After `load_done_i`, `czero_req_o` pulses for one cycle. The target reset is released only after `czero_ack_i`. `load_target_i`=0 selects `rst_app_n_o` and 1 selects `rst_rt_n_o`, and only one of the two is ever released.
- R10: If the wipe request is not acknowledged within the timeout, error bit 4 is set and, without lockdown, the target reset is released anyway.
- R11: Resets are released in order: `rst_s2_n_o` first, then `rst_s3_n_o`, then the final target.
- R12: Error bits are sticky: once set they stay set until power-on reset.
- R13: A hash engine that does not return done within TMO_CYCLES+1 waiting cycles counts as a digest failure of that step (bit 2 or bit 3, with the same consequences).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| power_ok | input | 1 | Supply valid; starts the chain |
| mode_secure_i | input | 1 | Requested security mode, latched once |
| fuse_bist_en | input | 1 | Fuse: run self test |
| fuse_err_hide | input | 1 | Fuse: zero the debug copy of the error word |
| fuse_lock_on_err | input | 1 | Fuse: any boot error locks the device |
| bank_clr_o | output | 1 | Clear pulse to the register bank |
| bank_addr_o | output | AW | Readback address |
| bank_rdata_i | input | BANK_W | Readback data |
| bist_start_o | output | 1 | Self-test start pulse |
| bist_done_i | input | 1 | Self-test done |
| bist_pass_i | input | 1 | Self-test result, valid with done |
| hash_start_o | output | 1 | Hash start pulse |
| hash_rom_sel_o | output | 1 | 0: stage-2 ROM, 1: stage-3 ROM |
| hash_done_i | input | 1 | Hash finished |
| dig_idx_o | output | DW | Digest word index under comparison |
| dig_word_i | input | WORD_W | Computed digest word at the index |
| gold_word_i | input | WORD_W | Golden digest word at the index |
| load_done_i | input | 1 | Third stage has loaded the boot image |
| load_target_i | input | 1 | 0: application processor, 1: real-time processor |
| czero_req_o | output | 1 | Crypto storage wipe request pulse |
| czero_ack_i | input | 1 | Wipe acknowledge |
| rst_s2_n_o | output | 1 | Stage-2 reset, active low |
| rst_s3_n_o | output | 1 | Stage-3 reset, active low |
| rst_app_n_o | output | 1 | Application processor reset, active low |
| rst_rt_n_o | output | 1 | Real-time processor reset, active low |
| secure_mode_o | output | 1 | Latched security mode |
| lockdown_o | output | 1 | Terminal lockdown state |
| err_status_o | output | 5 | Internal error word (bit0 clear, bit1 self test, bit2 digest 1, bit3 digest 2, bit4 wipe) |
| dbg_err_o | output | 5 | Debug-port copy of the error word |

## Verification
The hardest situation to reach is an error late in the chain combined with the lockdown fuse. The second digest mismatch arrives after `rst_s2_n_o` has already been released, so the lockdown must pull back a reset that is already open. The bench reaches it by serving a correct first digest and corrupting only word 0 of the second, which is recognisable through `hash_rom_sel_o`. It also corrupts only the last word of the first digest and the last bank address, which shows that the sticky comparators look at the final beat. Missing responses are produced by muting the hash or wipe responder, so that the timeout path is the only way forward.

// File: rtl/sbseq_pkg.sv
package sbseq_pkg;

   localparam int ERR_N  = 5;
   localparam int E_ZERO = 0;
   localparam int E_BIST = 1;
   localparam int E_H1   = 2;
   localparam int E_H2   = 3;
   localparam int E_CZ   = 4;

   typedef enum logic [4:0] {
      ST_IDLE, ST_ZCLR, ST_ZRD, ST_ZEND,
      ST_BGO, ST_BWAIT,
      ST_H1GO, ST_H1WAIT, ST_H1CMP, ST_H1END,
      ST_H2GO, ST_H2WAIT, ST_H2CMP, ST_H2END,
      ST_LOAD, ST_CZGO, ST_CZWAIT,
      ST_RUN, ST_HALT, ST_LOCK
   } seq_st_e;

endpackage

// File: rtl/sbseq_sticky_cmp.sv
module sbseq_sticky_cmp #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         diff
);
   if (W < 1) begin : g_bad_w
      $error("sbseq_sticky_cmp: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              diff <= 1'b0;
      else if (clr)            diff <= 1'b0;
      else if (en && (a != b)) diff <= 1'b1;
   end
endmodule

// File: rtl/sbseq_hs_timer.sv
module sbseq_hs_timer #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("sbseq_hs_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cnt_q <= '0;
      else if (clr)                            cnt_q <= '0;
      else if (run && (cnt_q != CW'(LIMIT)))   cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/sboot_seq.sv
module sboot_seq
   import sbseq_pkg::*;
#(
   parameter int NREGS        = 8,
   parameter int BANK_W       = 32,
   parameter int DIG_W        = 384,
   parameter int WORD_W       = 32,
   parameter int TMO_CYCLES   = 64,
   parameter bit BIST_PRESENT = 1'b1,
   localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1,
   localparam int DW = ((DIG_W / WORD_W) > 1) ? $clog2(DIG_W / WORD_W) : 1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              power_ok,
   input  logic              mode_secure_i,
   input  logic              fuse_bist_en,
   input  logic              fuse_err_hide,
   input  logic              fuse_lock_on_err,
   output logic              bank_clr_o,
   output logic [AW-1:0]     bank_addr_o,
   input  logic [BANK_W-1:0] bank_rdata_i,
   output logic              bist_start_o,
   input  logic              bist_done_i,
   input  logic              bist_pass_i,
   output logic              hash_start_o,
   output logic              hash_rom_sel_o,
   input  logic              hash_done_i,
   output logic [DW-1:0]     dig_idx_o,
   input  logic [WORD_W-1:0] dig_word_i,
   input  logic [WORD_W-1:0] gold_word_i,
   input  logic              load_done_i,
   input  logic              load_target_i,
   output logic              czero_req_o,
   input  logic              czero_ack_i,
   output logic              rst_s2_n_o,
   output logic              rst_s3_n_o,
   output logic              rst_app_n_o,
   output logic              rst_rt_n_o,
   output logic              secure_mode_o,
   output logic              lockdown_o,
   output logic [ERR_N-1:0]  err_status_o,
   output logic [ERR_N-1:0]  dbg_err_o
);
   localparam int DIG_WORDS = DIG_W / WORD_W;
   localparam int IW        = (AW > DW) ? AW : DW;

   if (DIG_W % WORD_W != 0) begin : g_bad_dig
      $error("sboot_seq: DIG_W must be a multiple of WORD_W");
   end
   if (NREGS < 2) begin : g_bad_nregs
      $error("sboot_seq: NREGS must be at least 2");
   end
   if (DIG_WORDS < 2) begin : g_bad_words
      $error("sboot_seq: digest must span at least two words");
   end

   seq_st_e          st_q, nxt_st;
   logic [IW-1:0]    idx_q, idx_nxt;
   logic [3:0]       rel_q, rel_set;
   logic [ERR_N-1:0] err_q, err_set;
   logic             mode_q, mode_nxt;
   logic             tgt_q, tgt_nxt;
   logic             bist_on, tmo, zdiff, ddiff;
   logic             is_go, is_wait, is_dcmp;

   // Self-test option: the fuse only counts when the test logic exists.
   if (BIST_PRESENT) begin : g_bist
      assign bist_on = fuse_bist_en;
   end else begin : g_no_bist
      assign bist_on = 1'b0;
   end

   assign is_go   = (st_q == ST_BGO) || (st_q == ST_H1GO) ||
                    (st_q == ST_H2GO) || (st_q == ST_CZGO);
   assign is_wait = (st_q == ST_BWAIT) || (st_q == ST_H1WAIT) ||
                    (st_q == ST_H2WAIT) || (st_q == ST_CZWAIT);
   assign is_dcmp = (st_q == ST_H1CMP) || (st_q == ST_H2CMP);

   sbseq_hs_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
      .clk(clk), .rst_n(por_n), .clr(is_go), .run(is_wait), .expired(tmo)
   );

   sbseq_sticky_cmp #(.W(BANK_W)) u_zcmp (
      .clk(clk), .rst_n(por_n), .clr(st_q == ST_ZCLR), .en(st_q == ST_ZRD),
      .a(bank_rdata_i), .b('0), .diff(zdiff)
   );

   sbseq_sticky_cmp #(.W(WORD_W)) u_dcmp (
      .clk(clk), .rst_n(por_n), .clr((st_q == ST_H1GO) || (st_q == ST_H2GO)),
      .en(is_dcmp), .a(dig_word_i), .b(gold_word_i), .diff(ddiff)
   );

   always_comb begin
      nxt_st   = st_q;
      idx_nxt  = idx_q;
      rel_set  = '0;
      err_set  = '0;
      mode_nxt = mode_q;
      tgt_nxt  = tgt_q;
      unique case (st_q)
         ST_IDLE: if (power_ok) begin
            mode_nxt = mode_secure_i;
            nxt_st   = ST_ZCLR;
         end
         ST_ZCLR: begin
            idx_nxt = '0;
            nxt_st  = ST_ZRD;
         end
         ST_ZRD: if (idx_q == IW'(NREGS - 1)) begin
            idx_nxt = '0;
            nxt_st  = ST_ZEND;
         end else begin
            idx_nxt = idx_q + 1'b1;
         end
         ST_ZEND: begin
            err_set[E_ZERO] = zdiff;
            if (zdiff && fuse_lock_on_err) nxt_st = ST_LOCK;
            else                           nxt_st = bist_on ? ST_BGO : ST_H1GO;
         end
         ST_BGO: nxt_st = ST_BWAIT;
         ST_BWAIT: if (bist_done_i || tmo) begin
            err_set[E_BIST] = !(bist_done_i && bist_pass_i);
            nxt_st = (err_set[E_BIST] && fuse_lock_on_err) ? ST_LOCK : ST_H1GO;
         end
         ST_H1GO: nxt_st = ST_H1WAIT;
         ST_H1WAIT: if (hash_done_i) begin
            idx_nxt = '0;
            nxt_st  = ST_H1CMP;
         end else if (tmo) begin
            err_set[E_H1] = 1'b1;
            nxt_st = fuse_lock_on_err ? ST_LOCK : ST_HALT;
         end
         ST_H1CMP: if (idx_q == IW'(DIG_WORDS - 1)) begin
            idx_nxt = '0;
            nxt_st  = ST_H1END;
         end else begin
            idx_nxt = idx_q + 1'b1;
         end
         ST_H1END: if (ddiff) begin
            err_set[E_H1] = 1'b1;
            nxt_st = fuse_lock_on_err ? ST_LOCK : ST_HALT;
         end else begin
            rel_set[0] = 1'b1;
            nxt_st     = ST_H2GO;
         end
         ST_H2GO: nxt_st = ST_H2WAIT;
         ST_H2WAIT: if (hash_done_i) begin
            idx_nxt = '0;
            nxt_st  = ST_H2CMP;
         end else if (tmo) begin
            err_set[E_H2] = 1'b1;
            rel_set[1]    = 1'b1;
            nxt_st = fuse_lock_on_err ? ST_LOCK : ST_LOAD;
         end
         ST_H2CMP: if (idx_q == IW'(DIG_WORDS - 1)) begin
            idx_nxt = '0;
            nxt_st  = ST_H2END;
         end else begin
            idx_nxt = idx_q + 1'b1;
         end
         ST_H2END: begin
            err_set[E_H2] = ddiff;
            rel_set[1]    = 1'b1;
            nxt_st = (ddiff && fuse_lock_on_err) ? ST_LOCK : ST_LOAD;
         end
         ST_LOAD: if (load_done_i) begin
            tgt_nxt = load_target_i;
            nxt_st  = ST_CZGO;
         end
         ST_CZGO: nxt_st = ST_CZWAIT;
         ST_CZWAIT: if (czero_ack_i || tmo) begin
            err_set[E_CZ] = !czero_ack_i;
            rel_set[tgt_q ? 3 : 2] = 1'b1;
            nxt_st = (!czero_ack_i && fuse_lock_on_err) ? ST_LOCK : ST_RUN;
         end
         default: nxt_st = st_q;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         rel_q  <= '0;
         err_q  <= '0;
         mode_q <= 1'b0;
         tgt_q  <= 1'b0;
      end else begin
         st_q   <= nxt_st;
         idx_q  <= idx_nxt;
         rel_q  <= (nxt_st == ST_LOCK) ? 4'b0000 : (rel_q | rel_set);
         err_q  <= err_q | err_set;
         mode_q <= mode_nxt;
         tgt_q  <= tgt_nxt;
      end
   end

   assign bank_clr_o     = (st_q == ST_ZCLR);
   assign bank_addr_o    = idx_q[AW-1:0];
   assign bist_start_o   = (st_q == ST_BGO);
   assign hash_start_o   = (st_q == ST_H1GO) || (st_q == ST_H2GO);
   assign hash_rom_sel_o = (st_q == ST_H2GO) || (st_q == ST_H2WAIT) ||
                           (st_q == ST_H2CMP) || (st_q == ST_H2END);
   assign dig_idx_o      = idx_q[DW-1:0];
   assign czero_req_o    = (st_q == ST_CZGO);
   assign rst_s2_n_o     = rel_q[0];
   assign rst_s3_n_o     = rel_q[1];
   assign rst_app_n_o    = rel_q[2];
   assign rst_rt_n_o     = rel_q[3];
   assign secure_mode_o  = mode_q;
   assign lockdown_o     = (st_q == ST_LOCK);
   assign err_status_o   = err_q;
   assign dbg_err_o      = fuse_err_hide ? '0 : err_q;
endmodule

// File: rtl/sbseq_chk.sv
module sbseq_chk
   import sbseq_pkg::*;
(
   input logic             clk,
   input logic             por_n,
   input logic             fuse_bist_en,
   input logic             bist_start_o,
   input logic             hash_start_o,
   input logic             czero_req_o,
   input logic             czero_ack_i,
   input logic             rst_s2_n_o,
   input logic             rst_s3_n_o,
   input logic             rst_app_n_o,
   input logic             rst_rt_n_o,
   input logic             secure_mode_o,
   input logic             lockdown_o,
   input logic [ERR_N-1:0] err_status_o
);
   // R7
   lock_all_held_chk: assert property (@(posedge clk) disable iff (!por_n)
      lockdown_o |-> !(rst_s2_n_o || rst_s3_n_o || rst_app_n_o || rst_rt_n_o));

   // R11
   s3_after_s2_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_s3_n_o |-> rst_s2_n_o);

   // R11
   tgt_after_s3_chk: assert property (@(posedge clk) disable iff (!por_n)
      (rst_app_n_o || rst_rt_n_o) |-> rst_s3_n_o);

   // R9
   one_target_chk: assert property (@(posedge clk) disable iff (!por_n)
      !(rst_app_n_o && rst_rt_n_o));

   // R9
   czero_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
      czero_req_o |=> !czero_req_o);

   // R9
   app_after_ack_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_app_n_o) |-> ($past(czero_ack_i) || err_status_o[E_CZ]));

   // R4
   hash_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
      hash_start_o |=> !hash_start_o);

   // R3
   bist_gated_chk: assert property (@(posedge clk) disable iff (!por_n)
      bist_start_o |-> fuse_bist_en);

   // R8
   mode_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
      (rst_s2_n_o && $past(rst_s2_n_o)) |-> $stable(secure_mode_o));

   // R12
   err_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      ((err_status_o & $past(err_status_o)) == $past(err_status_o)));
endmodule

bind sboot_seq sbseq_chk chk_i (
   .clk(clk), .por_n(por_n), .fuse_bist_en(fuse_bist_en),
   .bist_start_o(bist_start_o), .hash_start_o(hash_start_o),
   .czero_req_o(czero_req_o), .czero_ack_i(czero_ack_i),
   .rst_s2_n_o(rst_s2_n_o), .rst_s3_n_o(rst_s3_n_o),
   .rst_app_n_o(rst_app_n_o), .rst_rt_n_o(rst_rt_n_o),
   .secure_mode_o(secure_mode_o), .lockdown_o(lockdown_o),
   .err_status_o(err_status_o)
);

// File: tb/sboot_seq_tb_top.sv
module sboot_seq_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic por_n = 1'b0, power_ok = 1'b0, mode_secure_i = 1'b0;
   logic fuse_bist_en = 1'b0, fuse_err_hide = 1'b0, fuse_lock_on_err = 1'b0;
   logic bank_clr_o, bist_start_o, hash_start_o, hash_rom_sel_o, czero_req_o;
   logic [2:0]  bank_addr_o;
   logic [3:0]  dig_idx_o;
   logic [31:0] bank_rdata_i, dig_word_i, gold_word_i;
   logic bist_done_i = 1'b0, bist_pass_i = 1'b0, hash_done_i = 1'b0;
   logic load_done_i = 1'b0, load_target_i = 1'b0, czero_ack_i = 1'b0;
   logic rst_s2_n_o, rst_s3_n_o, rst_app_n_o, rst_rt_n_o, secure_mode_o, lockdown_o;
   logic [4:0] err_status_o, dbg_err_o;

   sboot_seq dut_i (.*);

   // bench configuration
   int  c_fault = -1, c_bad1 = -1, c_bad2 = -1, c_czdly = 1;
   bit  c_bist_pass = 1, c_bist_resp = 1, c_resp1 = 1, c_resp2 = 1, c_czresp = 1;
   int  n_bist, n_hash, n_czcyc, n_early;
   bit  ack_seen;
   int  total = 0, bad = 0;

   assign bank_rdata_i = (c_fault == int'(bank_addr_o)) ? 32'h0000_0100 : 32'h0;
   assign gold_word_i  = 32'h0101_0101 * (32'(dig_idx_o) + 1) +
                         (hash_rom_sel_o ? 32'h5000_0000 : 32'h0);
   assign dig_word_i   = gold_word_i ^
      (((hash_rom_sel_o ? c_bad2 : c_bad1) == int'(dig_idx_o)) ? 32'h8 : 32'h0);

   typedef struct {
      string      tag;
      logic [3:0] rst;
      logic       lock;
      logic [4:0] err;
      logic [4:0] dbg;
      logic       mode;
      int         bist, hash, czcyc, early;
   } exp_t;
   exp_t exp_q[$];
   event smp_ev;

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   // responders, all on the falling edge
   initial forever begin
      @(negedge clk);
      if (bist_start_o) begin
         n_bist++;
         if (c_bist_resp) begin
            repeat (3) @(negedge clk);
            bist_done_i = 1'b1; bist_pass_i = c_bist_pass;
            @(negedge clk);
            bist_done_i = 1'b0; bist_pass_i = 1'b0;
         end
      end
   end

   initial forever begin
      @(negedge clk);
      if (hash_start_o) begin
         n_hash++;
         if (hash_rom_sel_o ? c_resp2 : c_resp1) begin
            repeat (3) @(negedge clk);
            hash_done_i = 1'b1;
            @(negedge clk);
            hash_done_i = 1'b0;
         end
      end
   end

   initial forever begin
      @(negedge clk);
      if (czero_req_o && c_czresp) begin
         repeat (c_czdly) @(negedge clk);
         czero_ack_i = 1'b1; ack_seen = 1'b1;
         @(negedge clk);
         czero_ack_i = 1'b0;
      end
   end

   initial forever begin
      @(negedge clk);
      if (czero_req_o) n_czcyc++;
      if ((rst_app_n_o || rst_rt_n_o) && !ack_seen) n_early = 1;
   end

   // monitor: pops the expected record and compares the ports
   initial forever begin
      exp_t e;
      @(smp_ev);
      e = exp_q.pop_front();
      check({e.tag, " R11/R9 resets {rt,app,s3,s2}"},
            {rst_rt_n_o, rst_app_n_o, rst_s3_n_o, rst_s2_n_o}, e.rst);
      check({e.tag, " R7 lockdown"}, lockdown_o, e.lock);
      check({e.tag, " R12 error word"}, err_status_o, e.err);
      check({e.tag, " R6 debug error word"}, dbg_err_o, e.dbg);
      check({e.tag, " R8 latched mode"}, secure_mode_o, e.mode);
      check({e.tag, " R3 self-test starts"}, n_bist, e.bist);
      check({e.tag, " R4/R5 hash starts"}, n_hash, e.hash);
      check({e.tag, " R9 wipe request cycles"}, n_czcyc, e.czcyc);
      check({e.tag, " R9/R10 release before ack"}, n_early, e.early);
   end

   task automatic run_case(input string tag, input bit bist_en, hide, lock, mode, tgt,
                           input int fault, input bit bpass, bresp,
                           input int bad1, bad2, input bit r1, r2, czr, input int czdly);
      exp_t e;
      bit locked, halted, cz;
      @(negedge clk);
      por_n = 1'b0; power_ok = 1'b0;
      fuse_bist_en = bist_en; fuse_err_hide = hide; fuse_lock_on_err = lock;
      mode_secure_i = mode; load_target_i = tgt; load_done_i = 1'b1;
      c_fault = fault; c_bist_pass = bpass; c_bist_resp = bresp;
      c_bad1 = bad1; c_bad2 = bad2; c_resp1 = r1; c_resp2 = r2;
      c_czresp = czr; c_czdly = czdly;
      n_bist = 0; n_hash = 0; n_czcyc = 0; n_early = 0; ack_seen = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1; power_ok = 1'b1;
      repeat (30) @(negedge clk);
      mode_secure_i = ~mode;        // R8: must be ignored
      repeat (400) @(negedge clk);

      // expected outcome from the requirements
      e = '{tag: tag, rst: 4'b0, lock: 0, err: 5'b0, dbg: 5'b0, mode: mode,
            bist: 0, hash: 0, czcyc: 0, early: 0};
      locked = 0; halted = 0; cz = 0;
      if (fault >= 0) begin e.err[0] = 1; locked = lock; end
      if (!locked && bist_en) begin
         e.bist = 1;
         if (!bpass || !bresp) begin e.err[1] = 1; locked = lock; end
      end
      if (!locked) begin
         e.hash = 1;
         if (bad1 >= 0 || !r1) begin e.err[2] = 1; locked = lock; halted = !lock; end
         else e.rst[0] = 1;
      end
      if (!locked && !halted) begin
         e.hash = 2;
         if (bad2 >= 0 || !r2) begin e.err[3] = 1; locked = lock; end
         if (!locked) begin e.rst[1] = 1; cz = 1; end
      end
      if (cz) begin
         e.czcyc = 1;
         if (!czr) begin e.err[4] = 1; locked = lock; end
         if (!locked) begin e.rst[tgt ? 3 : 2] = 1; e.early = czr ? 0 : 1; end
      end
      if (locked) begin e.rst = 4'b0; e.lock = 1; end
      e.dbg = hide ? 5'b0 : e.err;
      exp_q.push_back(e);
      ->smp_ev;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 resets held", {rst_rt_n_o, rst_app_n_o, rst_s3_n_o, rst_s2_n_o}, 4'b0);
      check("R1 lockdown", lockdown_o, 1'b0);
      check("R1 error word", err_status_o, 5'b0);
      check("R1 requests", {bank_clr_o, bist_start_o, hash_start_o, czero_req_o}, 4'b0);
      //        tag    bist hide lock mode tgt fault pass bresp bad1 bad2 r1 r2 czr dly
      run_case("R11 clean",      0, 0, 0, 1, 0, -1, 1, 1, -1, -1, 1, 1, 1, 1);
      run_case("R3 bist pass",   1, 0, 0, 0, 1, -1, 1, 1, -1, -1, 1, 1, 1, 1);
      run_case("R3 bist fail",   1, 0, 0, 1, 0, -1, 0, 1, -1, -1, 1, 1, 1, 1);
      run_case("R2 bank fault",  0, 0, 0, 0, 0,  7, 1, 1, -1, -1, 1, 1, 1, 1);
      run_case("R4 last word",   0, 0, 0, 1, 0, -1, 1, 1, 11, -1, 1, 1, 1, 1);
      run_case("R5 h2 word0",    0, 0, 0, 1, 1, -1, 1, 1, -1,  0, 1, 1, 1, 1);
      run_case("R7 h2 lock",     0, 0, 1, 0, 0, -1, 1, 1, -1,  0, 1, 1, 1, 1);
      run_case("R6 hidden",      0, 1, 0, 1, 0,  3, 1, 1, -1, -1, 1, 1, 1, 1);
      run_case("R13 h1 timeout", 0, 0, 0, 0, 0, -1, 1, 1, -1, -1, 0, 1, 1, 1);
      run_case("R13 h2 timeout", 0, 0, 0, 0, 1, -1, 1, 1, -1, -1, 1, 0, 1, 1);
      run_case("R10 cz timeout", 0, 0, 0, 1, 0, -1, 1, 1, -1, -1, 1, 1, 0, 1);
      run_case("R9 cz slow",     0, 0, 0, 0, 1, -1, 1, 1, -1, -1, 1, 1, 1, 10);
      run_case("R7 bist lock",   1, 1, 1, 1, 0, -1, 1, 0, -1, -1, 1, 1, 1, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog R1..chain act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule